// File: doc/BRIEF.md
# Programmable Inter-Packet Gap Timer

This block tells a 10 Mb/s Ethernet transmitter when the medium has been idle long enough for it to start a frame. Each time a frame ends, whether it was sent or received, the block starts counting bit-time ticks (0.1 µs each). It raises `gap_ok` once the required idle interval has elapsed. The transmitter defers while `gap_ok` is low.

The interval is 9.6 µs + 1.6 µs × N, which is a terminal count of 96 + 16 × N ticks. N is a 3-bit code taken from a 16-bit control word. One code applies after the node's own transmission and a separate code applies after a reception. Bit 15 of the word enables the programmable gaps. When that bit is written as 0, the upper seven bits return to their defaults. A hard reset, a stop command or an init command also restores those defaults. Bits 8:0 are stored and read back and have no other effect. A gap uses the terminal count captured when it starts, so a control-word write made during a gap applies from the next gap onward.

Top module: `ipg_timer`

## Requirements
- R1: After synchronous reset, `ctrl_word` reads 16'h6000 (enable bit 15 = 0, receive code [14:12] = 3'b110, transmit code [11:9] = 3'b000, bits [8:0] = 0) and `gap_ok` is 1.
- R2: A write with `wr_data[15]` = 1 and no stop/init in the same cycle stores all 16 bits, and they are readable on `ctrl_word` the next cycle.
- R3: A write with `wr_data[15]` = 0 stores `wr_data[8:0]` and forces `ctrl_word[15:9]` to 7'b0110000.
- R4: A stop or init pulse forces `ctrl_word[15:9]` to 7'b0110000 and leaves `ctrl_word[8:0]` unchanged, unless a write occurs in the same cycle, in which case bits [8:0] take the written value.
- R5: A `tx_done` or `rx_done` pulse drives `gap_ok` low on the next cycle and restarts the count. A `bit_tick` in the same cycle as the pulse is not counted.
- R6: After a `tx_done` pulse, `gap_ok` rises on the T-th counted tick, where T = 96 + 16 × `ctrl_word[11:9]`. After an `rx_done` pulse, T = 96 + 16 × `ctrl_word[14:12]`. These codes are sampled at the pulse. If both pulses occur in the same cycle, the receive code is used.
- R7: Once high, `gap_ok` stays high regardless of ticks or writes until the next `tx_done` or `rx_done`.
- R8: A control-word write during a gap does not change that gap's length. The next gap uses the new codes.
- R9: While bit 15 is 0, the gaps are 96 ticks after transmit and 192 ticks after receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| bit_tick | input | 1 | One-cycle pulse per 0.1 µs bit time |
| tx_done | input | 1 | Pulse: own transmission ended |
| rx_done | input | 1 | Pulse: reception ended |
| stop_cmd | input | 1 | Pulse: stop command, restores gap defaults |
| init_cmd | input | 1 | Pulse: init command, restores gap defaults |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control-word write data |
| ctrl_word | output | 16 | Current control word |
| gap_ok | output | 1 | Idle gap satisfied; transmission may start |

## Verification
A corrupted control-word field shows on `ctrl_word` one cycle after the write or command that caused it. A wrong terminal count or a wrong transmit/receive selection shows as `gap_ok` rising one or more ticks early or late. The error therefore appears within at most 208 ticks of the frame end. The bench sweeps all eight codes in both directions and checks the cycle before and the cycle of the rise. A miscounted tick in the event cycle, or a write leaking into a gap already running, moves that edge by a measurable number of ticks.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int CODE_W     = 3;
  localparam int WORD_W     = 16;
  localparam int LOW_W      = 9;
  localparam int BASE_TICKS = 96;
  localparam int STEP_TICKS = 16;
  localparam int MAX_TICKS  = BASE_TICKS + STEP_TICKS * ((1 << CODE_W) - 1);
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);

  localparam logic [CODE_W-1:0] RX_CODE_DEF = 3'b110;
  localparam logic [CODE_W-1:0] TX_CODE_DEF = 3'b000;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] rx_code;
    logic [CODE_W-1:0] tx_code;
    logic [LOW_W-1:0]  low;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, rx_code: RX_CODE_DEF,
                                 tx_code: TX_CODE_DEF, low: '0};
endpackage

// File: rtl/ipg_ctrl_reg.sv
module ipg_ctrl_reg
  import ipg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              force_def,
  output ctrl_t             ctrl
);
  ctrl_t wr_word;
  ctrl_t nxt;

  assign wr_word = ctrl_t'(wr_data);

  always_comb begin
    nxt = ctrl;
    if (wr_en) begin
      nxt.low = wr_word.low;
      if (wr_word.en && !force_def) begin
        nxt.en      = 1'b1;
        nxt.rx_code = wr_word.rx_code;
        nxt.tx_code = wr_word.tx_code;
      end else begin
        nxt.en      = 1'b0;
        nxt.rx_code = RX_CODE_DEF;
        nxt.tx_code = TX_CODE_DEF;
      end
    end else if (force_def) begin
      nxt.en      = 1'b0;
      nxt.rx_code = RX_CODE_DEF;
      nxt.tx_code = TX_CODE_DEF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= CTRL_RST;
    else     ctrl <= nxt;
  end
endmodule

// File: rtl/ipg_gap_sel.sv
module ipg_gap_sel
  import ipg_pkg::*;
(
  input  ctrl_t             ctrl,
  input  logic              rx_evt,
  output logic [CNT_W-1:0]  term
);
  logic [CODE_W-1:0] rx_eff;
  logic [CODE_W-1:0] tx_eff;
  logic [CODE_W-1:0] code;

  assign rx_eff = ctrl.en ? ctrl.rx_code : RX_CODE_DEF;
  assign tx_eff = ctrl.en ? ctrl.tx_code : TX_CODE_DEF;
  assign code   = rx_evt ? rx_eff : tx_eff;
  assign term   = CNT_W'(BASE_TICKS) + CNT_W'(STEP_TICKS) * CNT_W'(code);
endmodule

// File: rtl/ipg_gap_cnt.sv
module ipg_gap_cnt
  import ipg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] term_in,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      term_q <= CNT_W'(BASE_TICKS);
      done   <= 1'b1;
    end else if (start) begin
      cnt    <= '0;
      term_q <= term_in;
      done   <= 1'b0;
    end else if (tick && !done) begin
      cnt    <= cnt_inc;
      done   <= (cnt_inc == term_q);
    end
  end
endmodule

// File: rtl/ipg_timer.sv
module ipg_timer
  import ipg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              stop_cmd,
  input  logic              init_cmd,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              gap_ok
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] term;
  logic             frame_end;

  assign frame_end = tx_done | rx_done;
  assign ctrl_word = WORD_W'(ctrl);

  ipg_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .force_def(stop_cmd | init_cmd), .ctrl(ctrl)
  );

  ipg_gap_sel u_sel (
    .ctrl(ctrl), .rx_evt(rx_done), .term(term)
  );

  ipg_gap_cnt u_cnt (
    .clk(clk), .rst(rst), .start(frame_end), .term_in(term),
    .tick(bit_tick), .done(gap_ok)
  );
endmodule

// File: rtl/ipg_timer_chk.sv
module ipg_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        bit_tick,
  input logic        tx_done,
  input logic        rx_done,
  input logic        stop_cmd,
  input logic        init_cmd,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] ctrl_word,
  input logic        gap_ok
);
  p_evt_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_done || rx_done) |=> !gap_ok);

  p_ok_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (gap_ok && !tx_done && !rx_done) |=> gap_ok);

  p_no_tick_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (!gap_ok && !bit_tick && !tx_done && !rx_done) |=> !gap_ok);

  p_cmd_defaults_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd || init_cmd) |=> (ctrl_word[15:9] == 7'b0110000));

  p_cmd_keeps_low_r4: assert property (@(posedge clk) disable iff (rst)
    ((stop_cmd || init_cmd) && !wr_en) |=> $stable(ctrl_word[8:0]));

  p_disable_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[15]) |=> (ctrl_word[15:9] == 7'b0110000));

  p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[15] && !stop_cmd && !init_cmd) |=> (ctrl_word == $past(wr_data)));
endmodule

bind ipg_timer ipg_timer_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_done(tx_done),
  .rx_done(rx_done), .stop_cmd(stop_cmd), .init_cmd(init_cmd),
  .wr_en(wr_en), .wr_data(wr_data), .ctrl_word(ctrl_word), .gap_ok(gap_ok)
);

// File: tb/ipg_timer_bench.sv
module ipg_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic        stop_cmd = 1'b0, init_cmd = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_word;
  logic        gap_ok;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  ipg_timer u_ipg_timer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_done(tx_done),
    .rx_done(rx_done), .stop_cmd(stop_cmd), .init_cmd(init_cmd),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_word(ctrl_word), .gap_ok(gap_ok)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bit_tick = 0; tx_done = 0; rx_done = 0; stop_cmd = 0; init_cmd = 0; wr_en = 0;
  endtask

  task automatic write(logic [15:0] d);
    wr_en = 1; wr_data = d; step(); idle();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; step(); end
    bit_tick = 0;
  endtask

  // pulse an end event (tick raised in the same cycle too), then verify the rise edge
  task automatic gap(bit tx, bit rx, int t, string req);
    tx_done = tx; rx_done = rx; bit_tick = 1; step(); idle();
    check(req, {15'd0, gap_ok}, 16'd0);
    ticks(t - 1);
    check(req, {15'd0, gap_ok}, 16'd0);
    ticks(1);
    check(req, {15'd0, gap_ok}, 16'd1);
  endtask

  initial begin
    @(negedge clk); step(); step(); rst = 0;
    check("R1 ctrl", ctrl_word, 16'h6000);
    check("R1 ok", {15'd0, gap_ok}, 16'd1);

    // defaults while disabled
    gap(1, 0, 96, "R9 tx default");
    gap(0, 1, 192, "R9 rx default");

    // full sweep of both codes, programmable
    for (int n = 0; n < 8; n++) begin
      write({1'b1, 3'(7 - n), 3'(n), 9'h055});
      check("R2 write", ctrl_word, {1'b1, 3'(7 - n), 3'(n), 9'h055});
      gap(1, 0, 96 + 16 * n, "R6 tx sweep");
      gap(0, 1, 96 + 16 * (7 - n), "R6 rx sweep");
    end
    write({1'b1, 3'd2, 3'd5, 9'h000});
    gap(1, 1, 96 + 32, "R6 simultaneous rx wins");

    // sticky gap_ok
    ticks(50);
    write(16'hFFFF);
    check("R7 sticky", {15'd0, gap_ok}, 16'd1);

    // write during gap
    write({1'b1, 3'd0, 3'd0, 9'h000});
    tx_done = 1; step(); idle();
    ticks(10);
    write({1'b1, 3'd0, 3'd7, 9'h000});
    ticks(85);
    check("R8 old gap low", {15'd0, gap_ok}, 16'd0);
    ticks(1);
    check("R8 old gap rise", {15'd0, gap_ok}, 16'd1);
    gap(1, 0, 208, "R8 next gap new code");

    // disabling write
    write(16'h7E12);
    check("R3 disable write", ctrl_word, 16'h6012);

    // stop / init
    write(16'hF1AB);
    check("R2 readback", ctrl_word, 16'hF1AB);
    stop_cmd = 1; step(); idle();
    check("R4 stop", ctrl_word, 16'h61AB);
    write(16'hDE00 | 16'h0123);
    init_cmd = 1; step(); idle();
    check("R4 init", ctrl_word, 16'h6123);
    init_cmd = 1; wr_en = 1; wr_data = 16'hFFFF; step(); idle();
    check("R4 init with write", ctrl_word, 16'h61FF);

    // event restart mid-gap
    write({1'b1, 3'd0, 3'd1, 9'h000});
    tx_done = 1; step(); idle();
    ticks(60);
    gap(1, 0, 112, "R5 restart");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule